// File: doc/BRIEF.md
# Parallel Camera Sensor Capture Front-End

This block takes the signals of a parallel image sensor into the system-clock domain and queues the captured pixel words in a small first-in first-out buffer. The sensor side has a frame sync, a line sync, a pixel clock and a 20-bit data bus. None of these is used as a clock: all of them are oversampled by the faster system clock. The frame sync and pixel clock go through a two-flop synchronizer and their edges are detected from successive samples. The data bus is delayed by the same number of stages, so each word stays aligned with its pixel-clock edge.

There are two capture modes. In free-running mode the line sync is not looked at, and every active pixel-clock edge inside a frame stores one word. In line-qualified mode a word is stored only while the line sync is at its active level. Three configuration inputs select the frame-start edge, the line-sync active level and the pixel-clock active edge. The mode, the line level and the pixel edge are sampled at each detected frame start and hold for the whole frame. The first word stored in each frame carries a start-of-frame tag. The output is a valid/ready stream. A word that arrives while the buffer is full is discarded and raises a sticky overflow flag.

Top module: `cam_capture`

## Requirements
- R1: No word is stored between reset and the first detected frame-start edge, even while pixel-clock edges arrive.
- R2: `cfg_fs_fall` selects the frame-start edge of `sen_fsync`: 0 selects the rising edge, 1 selects the falling edge. The opposite edge never starts a frame.
- R3: `cfg_pc_fall` selects the active pixel-clock edge: 0 selects the rising edge, 1 selects the falling edge. A word is stored only on the active edge.
- R4: With `cfg_gated`=1 (line-qualified mode), a word is stored only while `sen_lsync` is at its active level.
- R5: `cfg_ls_low` selects the active level of `sen_lsync`: 0 means active high, 1 means active low.
- R6: With `cfg_gated`=0 (free-running mode), `sen_lsync` has no effect, and every active pixel-clock edge after a frame start stores the word on `sen_data`.
- R7: `out_sof` is 1 on the first word stored after each frame-start edge and 0 on every later word of that frame.
- R8: While `cap_en` is 0, no word is stored. A start-of-frame tag that is still pending passes on to the next word stored after `cap_en` returns to 1.
- R9: The values of `cfg_gated`, `cfg_ls_low` and `cfg_pc_fall` take effect only at the next frame-start edge. `cfg_fs_fall` acts at once.
- R10: The buffer holds 16 words and delivers them in order, shown ahead on `out_data` and `out_sof` while `out_valid` is 1. A word is removed on a clock where both `out_valid` and `out_ready` are 1. While `out_ready` is 0, the word held on the output does not change.
- R11: A word that arrives while the buffer holds 16 words is discarded and sets `ovf`. `ovf` stays at 1 until `ovf_clr` is 1 on a clock edge. After reset, `out_valid` and `ovf` are 0.
- R12: A word is first visible on `out_valid` after the third rising system-clock edge that follows the active pixel-clock transition at the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cap_en | input | 1 | Capture enable; 0 blocks all stores |
| cfg_gated | input | 1 | 1 selects line-qualified mode, 0 selects free-running mode |
| cfg_fs_fall | input | 1 | 1 selects the falling frame-sync edge as frame start |
| cfg_ls_low | input | 1 | 1 makes the line sync active low |
| cfg_pc_fall | input | 1 | 1 selects the falling pixel-clock edge as active |
| sen_fsync | input | 1 | Sensor frame sync |
| sen_lsync | input | 1 | Sensor line sync |
| sen_pclk | input | 1 | Sensor pixel clock, sampled as data |
| sen_data | input | 20 | Sensor pixel data bus |
| out_valid | output | 1 | Buffer holds at least one word |
| out_ready | input | 1 | Consumer accepts the shown word |
| out_data | output | 20 | Oldest buffered pixel word |
| out_sof | output | 1 | Start-of-frame tag of the shown word |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
A sensor pin change reaches the buffer after three rising system-clock edges: two synchronizer stages, then the buffer write. The bench therefore drives every sensor pin on a falling clock edge and holds it for four full cycles before it changes anything else or looks at an output. One directed check samples `out_valid` after exactly the second and the third edge, to pin down that latency. The `ovf` flag and the popping of a word each settle after one edge, so they are checked at the falling edge that follows the request.

// File: rtl/cam_capture_pkg.sv
package cam_capture_pkg;
  localparam int unsigned PIX_W      = 20;
  localparam int unsigned BUF_DEPTH  = 16;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic             sof;
    logic [PIX_W-1:0] pix;
  } cap_word_t;
endpackage

// File: rtl/cam_pipe.sv
module cam_pipe #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/cam_framer.sv
module cam_framer
  import cam_capture_pkg::*;
#(
  parameter int unsigned W = PIX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         cfg_gated,
  input  logic         cfg_fs_fall,
  input  logic         cfg_ls_low,
  input  logic         cfg_pc_fall,
  input  logic         fs_s,
  input  logic         ls_s,
  input  logic         pc_s,
  input  logic [W-1:0] pix_s,
  output logic         push,
  output logic         push_sof,
  output logic [W-1:0] push_pix,
  output logic         started
);
  logic fs_p_q, pc_p_q;
  logic act_gated_q, act_ls_low_q, act_pc_fall_q;
  logic act_gated_d, act_ls_low_d, act_pc_fall_d;
  logic started_q, started_d;
  logic tag_q, tag_d;
  logic sof_edge, pc_edge, line_on;

  always_comb begin
    sof_edge = cfg_fs_fall ? (fs_p_q & ~fs_s) : (fs_s & ~fs_p_q);
    pc_edge  = act_pc_fall_q ? (pc_p_q & ~pc_s) : (pc_s & ~pc_p_q);
    line_on  = ls_s ^ act_ls_low_q;
    push     = started_q & cap_en & pc_edge & (~act_gated_q | line_on);

    act_gated_d   = act_gated_q;
    act_ls_low_d  = act_ls_low_q;
    act_pc_fall_d = act_pc_fall_q;
    started_d     = started_q;
    if (sof_edge) begin
      act_gated_d   = cfg_gated;
      act_ls_low_d  = cfg_ls_low;
      act_pc_fall_d = cfg_pc_fall;
      started_d     = 1'b1;
    end

    if (sof_edge)  tag_d = 1'b1;
    else if (push) tag_d = 1'b0;
    else           tag_d = tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_p_q        <= 1'b0;
      pc_p_q        <= 1'b0;
      act_gated_q   <= 1'b0;
      act_ls_low_q  <= 1'b0;
      act_pc_fall_q <= 1'b0;
      started_q     <= 1'b0;
      tag_q         <= 1'b0;
    end else begin
      fs_p_q        <= fs_s;
      pc_p_q        <= pc_s;
      act_gated_q   <= act_gated_d;
      act_ls_low_q  <= act_ls_low_d;
      act_pc_fall_q <= act_pc_fall_d;
      started_q     <= started_d;
      tag_q         <= tag_d;
    end
  end

  assign push_sof = tag_q;
  assign push_pix = pix_s;
  assign started  = started_q;

  // R7: once a tagged word has gone out, the tag stays clear until a new frame start
  a_r7_sof_tag_once: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_sof && !sof_edge) |=> !push_sof);
endmodule

// File: rtl/cam_fifo.sv
module cam_fifo
  import cam_capture_pkg::*;
#(
  parameter int unsigned DEPTH = BUF_DEPTH,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  cap_word_t   push_word,
  input  logic        out_ready,
  output logic        out_valid,
  output cap_word_t   out_word,
  output logic [AW:0] level,
  output logic        ovf,
  input  logic        ovf_clr
);
  cap_word_t   mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, empty, wr, rd;

  always_comb begin
    full  = (cnt_q == (AW+1)'(DEPTH));
    empty = (cnt_q == '0);
    wr    = push & ~full;
    rd    = out_ready & ~empty;

    wp_d = wp_q;
    if (wr) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    rp_d = rp_q;
    if (rd) rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;

    if (wr && !rd)      cnt_d = cnt_q + 1'b1;
    else if (rd && !wr) cnt_d = cnt_q - 1'b1;
    else                cnt_d = cnt_q;

    if (push && full) ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp_q] <= push_word;
  end

  assign out_valid = ~empty;
  assign out_word  = mem[rp_q];
  assign level     = cnt_q;
  assign ovf       = ovf_q;

  // R11: a word offered to a full buffer raises the flag
  a_r11_full_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf_q);
  // R11: the flag holds until cleared
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R10: a stalled output word holds
  a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !out_ready) |=> (!empty && $stable(out_word)));
  // R10: occupancy never passes the depth
  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/cam_capture.sv
module cam_capture
  import cam_capture_pkg::*;
#(
  parameter int unsigned W     = PIX_W,
  parameter int unsigned DEPTH = BUF_DEPTH,
  parameter int unsigned SYNC  = SYNC_STAGES,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned SW   = W + 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         cfg_gated,
  input  logic         cfg_fs_fall,
  input  logic         cfg_ls_low,
  input  logic         cfg_pc_fall,
  input  logic         sen_fsync,
  input  logic         sen_lsync,
  input  logic         sen_pclk,
  input  logic [W-1:0] sen_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_sof,
  output logic         ovf,
  input  logic         ovf_clr
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [SW-1:0] raw_bus, sync_bus;
  assign raw_bus = {sen_fsync, sen_lsync, sen_pclk, sen_data};

  cam_pipe #(.W(SW), .STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .din  (raw_bus),
    .dout (sync_bus)
  );

  logic         push, push_sof, started;
  logic [W-1:0] push_pix;

  cam_framer #(.W(W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .cap_en     (cap_en),
    .cfg_gated  (cfg_gated),
    .cfg_fs_fall(cfg_fs_fall),
    .cfg_ls_low (cfg_ls_low),
    .cfg_pc_fall(cfg_pc_fall),
    .fs_s       (sync_bus[W+2]),
    .ls_s       (sync_bus[W+1]),
    .pc_s       (sync_bus[W]),
    .pix_s      (sync_bus[W-1:0]),
    .push       (push),
    .push_sof   (push_sof),
    .push_pix   (push_pix),
    .started    (started)
  );

  cap_word_t   in_word, head_word;
  logic [AW:0] level;
  assign in_word = '{sof: push_sof, pix: push_pix};

  cam_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .push     (push),
    .push_word(in_word),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_word (head_word),
    .level    (level),
    .ovf      (ovf),
    .ovf_clr  (ovf_clr)
  );

  assign out_data = head_word.pix;
  assign out_sof  = head_word.sof;

  // R1: nothing reaches the buffer before the first frame start
  a_r1_empty_before_sof: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!started) |=> !out_valid);
  // R8: with capture disabled the occupancy cannot grow
  a_r8_disabled_no_growth: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!cap_en) |=> (level <= $past(level)));
endmodule

// File: tb/cam_capture_test.sv
module cam_capture_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_en, cfg_gated, cfg_fs_fall, cfg_ls_low, cfg_pc_fall;
  logic        sen_fsync, sen_lsync, sen_pclk;
  logic [19:0] sen_data;
  logic        out_valid, out_ready, out_sof, ovf, ovf_clr;
  logic [19:0] out_data;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  cam_capture uut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .cfg_gated(cfg_gated), .cfg_fs_fall(cfg_fs_fall),
    .cfg_ls_low(cfg_ls_low), .cfg_pc_fall(cfg_pc_fall),
    .sen_fsync(sen_fsync), .sen_lsync(sen_lsync), .sen_pclk(sen_pclk),
    .sen_data(sen_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .ovf(ovf), .ovf_clr(ovf_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // frame start using the currently selected edge
  task automatic send_sof();
    sen_fsync = cfg_fs_fall;
    wait_n(6);
    sen_fsync = ~cfg_fs_fall;
    wait_n(6);
  endtask

  // one pixel-clock pulse; line_act gives the intended line state
  task automatic pulse(input logic [19:0] d, input logic line_act, input logic lvl_low,
                       input bit edge_chk, input logic pc_fall_act);
    sen_data  = d;
    sen_lsync = line_act ^ lvl_low;
    wait_n(4);
    sen_pclk = 1'b1;
    wait_n(4);
    if (edge_chk) chk("R3 rising-half store", 32'(out_valid), 32'(!pc_fall_act));
    sen_pclk = 1'b0;
    wait_n(4);
    if (edge_chk) chk("R3 full-pulse store", 32'(out_valid), 32'd1);
  endtask

  task automatic pop_expect(input string tag, input logic exp_sof, input logic [19:0] exp_d);
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " data"}, 32'(out_data), 32'(exp_d));
    chk({tag, " sof"}, 32'(out_sof), 32'(exp_sof));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_en = 1'b1; cfg_gated = 0; cfg_fs_fall = 0; cfg_ls_low = 0;
    cfg_pc_fall = 0; sen_fsync = 0; sen_lsync = 0; sen_pclk = 0; sen_data = '0;
    out_ready = 0; ovf_clr = 0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    chk("R11 reset valid", 32'(out_valid), 32'd0);
    chk("R11 reset ovf", 32'(ovf), 32'd0);

    // R1 / R2: rising edge while falling edge is selected does not start a frame
    cfg_fs_fall = 1'b1;
    sen_fsync = 1'b1;
    wait_n(6);
    pulse(20'h11111, 1'b1, 1'b0, 0, 1'b0);
    pulse(20'h22222, 1'b1, 1'b0, 0, 1'b0);
    chk("R1 R2 no store before frame start", 32'(out_valid), 32'd0);
    sen_fsync = 1'b0;
    wait_n(6);
    pulse(20'h33333, 1'b1, 1'b0, 0, 1'b0);
    pop_expect("R2 falling-edge frame", 1'b1, 20'h33333);

    // R12 latency, R7 untagged second word
    sen_data = 20'h44444;
    wait_n(4);
    sen_pclk = 1'b1;
    wait_n(2);
    chk("R12 not yet after two edges", 32'(out_valid), 32'd0);
    wait_n(1);
    chk("R12 visible after third edge", 32'(out_valid), 32'd1);
    sen_pclk = 1'b0;
    wait_n(4);
    pop_expect("R7 second word", 1'b0, 20'h44444);
    chk("R10 empty after pops", 32'(out_valid), 32'd0);

    // sweep over all 16 configurations
    for (int c = 0; c < 16; c++) begin
      logic g, lsl, pcf;
      g = c[0]; lsl = c[2]; pcf = c[3];
      cfg_gated = g; cfg_fs_fall = c[1]; cfg_ls_low = lsl; cfg_pc_fall = pcf;
      send_sof();
      for (int i = 0; i < 5; i++) begin
        logic act;
        act = (i != 1) && (i != 4);
        pulse(20'(c << 16) | 20'h05A00 | 20'(i), act, lsl, (i == 0), pcf);
      end
      begin
        bit first;
        first = 1'b1;
        for (int i = 0; i < 5; i++) begin
          logic act;
          act = (i != 1) && (i != 4);
          if (!g || act) begin
            pop_expect(g ? (lsl ? "R5 low-level line" : "R4 gated line") : "R6 line ignored",
                       first, 20'(c << 16) | 20'h05A00 | 20'(i));
            first = 1'b0;
          end
        end
      end
      chk(g ? "R4 inactive pixels dropped" : "R6 all pixels kept", 32'(out_valid), 32'd0);
    end

    // R9: mode change waits for the next frame start
    cfg_gated = 1; cfg_fs_fall = 0; cfg_ls_low = 0; cfg_pc_fall = 0;
    send_sof();
    cfg_gated = 0;
    pulse(20'h55555, 1'b0, 1'b0, 0, 1'b0);
    chk("R9 old mode kept in frame", 32'(out_valid), 32'd0);
    send_sof();
    pulse(20'h66666, 1'b0, 1'b0, 0, 1'b0);
    pop_expect("R9 new mode after frame start", 1'b1, 20'h66666);

    // R8: capture enable, tag carried over
    send_sof();
    cap_en = 1'b0;
    pulse(20'h77777, 1'b1, 1'b0, 0, 1'b0);
    pulse(20'h78787, 1'b1, 1'b0, 0, 1'b0);
    chk("R8 disabled stores nothing", 32'(out_valid), 32'd0);
    cap_en = 1'b1;
    pulse(20'h79797, 1'b1, 1'b0, 0, 1'b0);
    pop_expect("R8 tag after re-enable", 1'b1, 20'h79797);
    chk("R8 single word", 32'(out_valid), 32'd0);

    // R11 / R10: overflow
    send_sof();
    for (int i = 0; i < 17; i++) pulse(20'h30000 | 20'(i), 1'b1, 1'b0, 0, 1'b0);
    chk("R11 ovf set", 32'(ovf), 32'd1);
    for (int i = 0; i < 16; i++) pop_expect("R10 order", (i == 0), 20'h30000 | 20'(i));
    chk("R11 seventeenth dropped", 32'(out_valid), 32'd0);
    chk("R11 ovf sticky", 32'(ovf), 32'd1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R11 ovf cleared", 32'(ovf), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule